// File: doc/BRIEF.md
# Radix-Sort Self-Routing Permutation Network

This block moves up to N packets from N input lines to N output lines. N is a power of two. Each packet carries a destination address of log2 N bits, and no two packets may name the same output. The block works like a binary radix sort that starts at the most significant destination bit. It has log2 N separator stages. Stage k splits every sub-block of 2^(k+1) lines by destination bit k. Packets with a 0 in that bit are gathered into the upper half of the sub-block, and packets with a 1 are gathered into the lower half. After the stage for bit 0, each packet sits on the output line that matches its address.

Each separator has three parts:
- a distributor, which is a set of 1-to-2 demultiplexers steered by the current bit;
- two concentrators, one for each group. A concentrator ranks its packets by prefix count. It offsets the ranks by half the sub-block for the 1 group. It then steers the packets through an indirect binary cube of 2x2 switches, using the rank as the routing tag.

Each stage ends in a register, so the network takes a new set of packets every cycle. The only storage is the set of stage registers.

Lane j of a flat vector occupies bits `[j*AW +: AW]` of `in_addr`/`out_addr` and bits `[j*DW +: DW]` of `in_data`/`out_data`, where AW = log2 N. The reset input is asynchronous and active low. Its release is synchronised inside the block over two clock cycles.

Top module: `rsp_net`

## Requirements
- R1: While reset is held, and after its release until the first packets reach the output, every `out_valid` bit is 0 and every `out_addr`/`out_data` lane is 0.
- R2: A set of packets presented on the inputs in one cycle appears on the outputs exactly log2 N clock cycles later. A new set may be presented every cycle, and earlier or later sets do not disturb it.
- R3: A valid packet with destination address a leaves on output lane a with `out_valid[a]` = 1, `out_addr` lane a = a, and its data lane unchanged.
- R4: The number of valid outputs equals the number of valid inputs of the set. No packet is lost or duplicated.
- R5: An output lane that receives no packet drives valid 0, address 0 and data 0.
- R6: A full load (all N lanes valid, forming a full permutation) is routed correctly. An empty load (no lane valid) produces no valid output.
- R7: The address and data lanes of an input whose valid bit is 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-lane packet present |
| in_addr | input | N*AW | Per-lane destination address |
| in_data | input | N*DW | Per-lane payload |
| out_valid | output | N | Per-lane packet present at output |
| out_addr | output | N*AW | Per-lane address of the delivered packet |
| out_data | output | N*DW | Per-lane payload of the delivered packet |

## Verification
The bench drives the following patterns:
- **Fixed full permutations:** identity, reversal and an address-mixing pattern. These show whether every stage splits on the right bit.
- **Random full permutations:** these load both halves of every sub-block at once, which stresses the concentrator offsets.
- **Single isolated packets on every lane:** each is followed by idle cycles. These pin down the exact latency and show any leakage into neighbouring cycles.
- **Streams of random partial permutations:** these carry garbage on the unused lanes and run back to back. They separate correct ranking from reliance on the idle-lane fields.
- **An empty load:** this checks that nothing is created from nothing.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  // Group selected by the destination bit handled in a stage.
  typedef enum logic {
    GRP_LOW  = 1'b0,
    GRP_HIGH = 1'b1
  } grp_e;

  // Lines per sub-block at the stage that handles destination bit k.
  function automatic int unsigned block_lines(int unsigned k);
    return 32'd1 << (k + 1);
  endfunction
endpackage

// File: rtl/rsp_cube.sv
// Indirect binary cube: LSB-first stages of 2x2 switches. Each packet is
// steered so that its line index takes the bit of its tag for that stage.
module rsp_cube #(
  parameter int S  = 4,
  parameter int W  = 12,
  parameter int TW = $clog2(S)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [S*W-1:0]  in_pkt,
  input  logic [S*TW-1:0] in_tag,
  output logic [S*W-1:0]  out_pkt
);
  localparam int LG = $clog2(S);

  for (genvar m = 0; m < LG; m++) begin : g_stg
    logic [S*W-1:0]  pk_i, pk_o;
    logic [S*TW-1:0] tg_i, tg_o;

    if (m == 0) begin : g_first
      assign pk_i = in_pkt;
      assign tg_i = in_tag;
    end else begin : g_next
      assign pk_i = g_stg[m-1].pk_o;
      assign tg_i = g_stg[m-1].tg_o;
    end

    for (genvar j = 0; j < S; j++) begin : g_ln
      localparam int P   = j ^ (1 << m);
      localparam bit MYB = ((j >> m) & 1) != 0;
      logic keep, take;

      assign keep = pk_i[j*W + W-1] && (tg_i[j*TW + m] == MYB);
      assign take = pk_i[P*W + W-1] && (tg_i[P*TW + m] == MYB);

      assign pk_o[j*W +: W]   = keep ? pk_i[j*W +: W]   : (take ? pk_i[P*W +: W]   : '0);
      assign tg_o[j*TW +: TW] = keep ? tg_i[j*TW +: TW] : (take ? tg_i[P*TW +: TW] : '0);

      // R4: a switch never sees two packets claiming the same outlet.
      p_switch_no_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(keep && take));
    end
  end

  assign out_pkt = g_stg[LG-1].pk_o;
endmodule

// File: rtl/rsp_concentrator.sv
// Prefix-count ranking of selected lines, rank offset, then cube routing.
module rsp_concentrator #(
  parameter int S   = 4,
  parameter int W   = 12,
  parameter int OFF = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [S*W-1:0] in_pkt,
  input  logic [S-1:0]   in_take,
  output logic [S*W-1:0] out_pkt
);
  localparam int TW = $clog2(S);
  localparam int CW = TW + 1;
  localparam logic [CW-1:0] OFFV = CW'(OFF);

  logic [S*W-1:0]  sel_pkt;
  logic [S*TW-1:0] rank_tag;
  logic [CW-1:0]   run_cnt;
  logic [CW-1:0]   sum_v;

  always_comb begin
    run_cnt = '0;
    sum_v   = '0;
    sel_pkt  = '0;
    rank_tag = '0;
    for (int j = 0; j < S; j++) begin
      sum_v = run_cnt + OFFV;
      rank_tag[j*TW +: TW] = sum_v[TW-1:0];
      sel_pkt[j*W +: W]    = in_take[j] ? in_pkt[j*W +: W] : '0;
      run_cnt = run_cnt + {{TW{1'b0}}, in_take[j]};
    end
  end

  // R3: a group never exceeds the half sub-block it is concentrated into.
  p_group_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_take) <= S/2);

  rsp_cube #(.S(S), .W(W), .TW(TW)) u_cube (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_pkt  (sel_pkt),
    .in_tag  (rank_tag),
    .out_pkt (out_pkt)
  );
endmodule

// File: rtl/rsp_separator.sv
// One sub-block of a stage: distributor on bit K plus two concentrators.
module rsp_separator
  import rsp_pkg::*;
#(
  parameter int S  = 4,
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int K  = 1,
  parameter int W  = 1 + AW + DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [S*W-1:0] in_pkt,
  output logic [S*W-1:0] out_pkt
);
  logic [S-1:0]   take_lo, take_hi;
  logic [S*W-1:0] lo_pkt, hi_pkt;
  logic [S-1:0]   lo_v, hi_v;
  grp_e           grp;

  always_comb begin
    take_lo = '0;
    take_hi = '0;
    grp     = GRP_LOW;
    for (int j = 0; j < S; j++) begin
      grp = grp_e'(in_pkt[j*W + DW + K]);
      take_lo[j] = in_pkt[j*W + W-1] && (grp == GRP_LOW);
      take_hi[j] = in_pkt[j*W + W-1] && (grp == GRP_HIGH);
    end
  end

  rsp_concentrator #(.S(S), .W(W), .OFF(0)) u_conc_lo (
    .clk (clk), .rst_n (rst_n),
    .in_pkt (in_pkt), .in_take (take_lo), .out_pkt (lo_pkt)
  );

  rsp_concentrator #(.S(S), .W(W), .OFF(S/2)) u_conc_hi (
    .clk (clk), .rst_n (rst_n),
    .in_pkt (in_pkt), .in_take (take_hi), .out_pkt (hi_pkt)
  );

  always_comb begin
    for (int j = 0; j < S; j++) begin
      lo_v[j] = lo_pkt[j*W + W-1];
      hi_v[j] = hi_pkt[j*W + W-1];
    end
  end

  assign out_pkt = lo_pkt | hi_pkt;

  // R4: the two groups land on disjoint lines, so merging loses nothing.
  p_merge_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_v & hi_v) == '0);
  // R3: 0-group packets stay in the upper half, 1-group in the lower half.
  p_halves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_v >> (S/2)) == '0) && ((hi_v & S'((1 << (S/2)) - 1)) == '0));
endmodule

// File: rtl/rsp_net.sv
module rsp_net
  import rsp_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  input  logic [N*AW-1:0] in_addr,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*AW-1:0] out_addr,
  output logic [N*DW-1:0] out_data
);
  localparam int LG = $clog2(N);
  localparam int W  = 1 + AW + DW;

  // Reset release synchroniser.
  logic [1:0] rsync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  // Packing: idle lanes enter as all-zero so their fields cannot matter.
  logic [N*W-1:0] pkt_in;
  always_comb begin
    for (int j = 0; j < N; j++) begin
      pkt_in[j*W +: W] = in_valid[j] ? {1'b1, in_addr[j*AW +: AW], in_data[j*DW +: DW]} : '0;
    end
  end

  for (genvar s = 0; s < LG; s++) begin : g_st
    localparam int K  = LG - 1 - s;
    localparam int S  = int'(block_lines(K));
    localparam int NB = N / S;

    logic [N*W-1:0] src, nxt, q;
    logic [N-1:0]   vq;

    if (s == 0) begin : g_src0
      assign src = pkt_in;
    end else begin : g_srcn
      assign src = g_st[s-1].q;
    end

    for (genvar b = 0; b < NB; b++) begin : g_blk
      rsp_separator #(.S(S), .DW(DW), .AW(AW), .K(K), .W(W)) u_sep (
        .clk     (clk),
        .rst_n   (rst_ok),
        .in_pkt  (src[b*S*W +: S*W]),
        .out_pkt (nxt[b*S*W +: S*W])
      );
    end

    always_ff @(posedge clk or negedge rst_ok) begin
      if (!rst_ok) q <= '0;
      else         q <= nxt;
    end

    for (genvar j = 0; j < N; j++) begin : g_v
      localparam logic [AW-1:0] JA = AW'(j);
      assign vq[j] = q[j*W + W-1];
      // R3: after the stage for bit K, the upper address bits match the line.
      p_block_place_r3: assert property (@(posedge clk) disable iff (!rst_ok)
        vq[j] |-> (((q[j*W + DW +: AW] ^ JA) >> K) == '0));
    end

    if (s > 0) begin : g_cnt
      // R4: each stage hands on exactly as many packets as it received.
      p_count_kept_r4: assert property (@(posedge clk) disable iff (!rst_ok)
        $countones(vq) == $past($countones(g_st[s-1].vq)));
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      out_valid[j]          = g_st[LG-1].q[j*W + W-1];
      out_addr[j*AW +: AW]  = g_st[LG-1].q[j*W + DW +: AW];
      out_data[j*DW +: DW]  = g_st[LG-1].q[j*W +: DW];
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_chk
    localparam logic [AW-1:0] JA = AW'(j);
    // R3: a delivered packet sits on the lane named by its address.
    p_addr_match_r3: assert property (@(posedge clk) disable iff (!rst_ok)
      out_valid[j] |-> (out_addr[j*AW +: AW] == JA));
    // R5: an empty lane carries no stale fields.
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_ok)
      !out_valid[j] |-> ((out_addr[j*AW +: AW] == '0) && (out_data[j*DW +: DW] == '0)));
  end
endmodule

// File: tb/rsp_net_bench.sv
module rsp_net_bench;
  localparam int N   = 8;
  localparam int AW  = 3;
  localparam int DW  = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    in_valid = '0;
  logic [N*AW-1:0] in_addr  = '0;
  logic [N*DW-1:0] in_data  = '0;
  logic [N-1:0]    out_valid;
  logic [N*AW-1:0] out_addr;
  logic [N*DW-1:0] out_data;

  rsp_net #(.N(N), .DW(DW)) u_rsp_net (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_addr (in_addr), .in_data (in_data),
    .out_valid (out_valid), .out_addr (out_addr), .out_data (out_data)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [N-1:0]    qv[$];
  logic [N*AW-1:0] qa[$];
  logic [N*DW-1:0] qd[$];
  string           qt[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(logic [N-1:0] v, logic [N*AW-1:0] a, logic [N*DW-1:0] d, string tag);
    logic [N-1:0]    ev = '0;
    logic [N*AW-1:0] ea = '0;
    logic [N*DW-1:0] ed = '0;
    for (int j = 0; j < N; j++) begin
      if (v[j]) begin
        int t = int'(a[j*AW +: AW]);
        ev[t] = 1'b1;
        ea[t*AW +: AW] = AW'(t);
        ed[t*DW +: DW] = d[j*DW +: DW];
      end
    end
    qv.push_back(ev); qa.push_back(ea); qd.push_back(ed); qt.push_back(tag);
  endtask

  task automatic compare_out();
    logic [N-1:0]    ev = qv.pop_front();
    logic [N*AW-1:0] ea = qa.pop_front();
    logic [N*DW-1:0] ed = qd.pop_front();
    string           tg = qt.pop_front();
    for (int j = 0; j < N; j++) begin
      if (ev[j]) begin
        check(out_valid[j] == 1'b1, {tg, "/R3"}, $sformatf("lane %0d valid", j), int'(out_valid[j]), 1);
        check(out_addr[j*AW +: AW] == ea[j*AW +: AW], {tg, "/R3"}, $sformatf("lane %0d addr", j),
              int'(out_addr[j*AW +: AW]), int'(ea[j*AW +: AW]));
        check(out_data[j*DW +: DW] == ed[j*DW +: DW], {tg, "/R3"}, $sformatf("lane %0d data", j),
              int'(out_data[j*DW +: DW]), int'(ed[j*DW +: DW]));
      end else begin
        check(out_valid[j] == 1'b0, {tg, "/R5"}, $sformatf("lane %0d idle valid", j), int'(out_valid[j]), 0);
        check(out_addr[j*AW +: AW] == '0 && out_data[j*DW +: DW] == '0, {tg, "/R5"},
              $sformatf("lane %0d idle fields", j),
              int'({out_addr[j*AW +: AW], out_data[j*DW +: DW]}), 0);
      end
    end
    check($countones(out_valid) == $countones(ev), {tg, "/R4"}, "packet count",
          $countones(out_valid), $countones(ev));
  endtask

  task automatic step(logic [N-1:0] v, logic [N*AW-1:0] a, logic [N*DW-1:0] d, string tag);
    @(negedge clk);
    compare_out();
    in_valid = v; in_addr = a; in_data = d;
    push_exp(v, a, d, tag);
  endtask

  task automatic idle(string tag);
    step('0, '0, '0, tag);
  endtask

  task automatic rand_perm(output logic [N*AW-1:0] a);
    int p[N];
    for (int j = 0; j < N; j++) p[j] = j;
    for (int j = N-1; j > 0; j--) begin
      int r = int'($urandom_range(j, 0));
      int t = p[j]; p[j] = p[r]; p[r] = t;
    end
    for (int j = 0; j < N; j++) a[j*AW +: AW] = AW'(p[j]);
  endtask

  task automatic rand_data(output logic [N*DW-1:0] d);
    for (int j = 0; j < N; j++) d[j*DW +: DW] = DW'($urandom);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    logic [N*AW-1:0] a;
    logic [N*DW-1:0] d;
    logic [N-1:0]    v;

    // R1: reset state, with live-looking inputs held during reset.
    in_valid = '1;
    for (int j = 0; j < N; j++) in_addr[j*AW +: AW] = AW'(j);
    in_data = '1;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == '0 && out_addr == '0 && out_data == '0, "R1", "outputs in reset",
            int'(out_valid), 0);
    end
    in_valid = '0; in_addr = '0; in_data = '0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == '0 && out_addr == '0 && out_data == '0, "R1", "outputs after release",
          int'(out_valid), 0);

    for (int j = 0; j < LAT-1; j++) push_exp('0, '0, '0, "R1");
    push_exp('0, '0, '0, "R1");

    // R6: fixed full permutations.
    for (int j = 0; j < N; j++) a[j*AW +: AW] = AW'(j);
    rand_data(d); step('1, a, d, "R6");
    for (int j = 0; j < N; j++) a[j*AW +: AW] = AW'(N-1-j);
    rand_data(d); step('1, a, d, "R6");
    for (int j = 0; j < N; j++) a[j*AW +: AW] = AW'((j*3 + 5) % N);
    rand_data(d); step('1, a, d, "R6");
    // R6: random full permutations back to back.
    for (int i = 0; i < 12; i++) begin
      rand_perm(a); rand_data(d); step('1, a, d, "R6");
    end
    // R6: empty load.
    idle("R6"); idle("R6");

    // R2: isolated single packets, exact latency and no leakage.
    for (int j = 0; j < N; j++) begin
      v = '0; v[j] = 1'b1;
      a = '0; a[j*AW +: AW] = AW'((j*5 + 3) % N);
      d = '0; d[j*DW +: DW] = DW'(8'h40 + j);
      step(v, a, d, "R2");
      repeat (LAT) idle("R2");
    end

    // R7: random partial permutations with garbage on idle lanes.
    for (int i = 0; i < 60; i++) begin
      logic [N*AW-1:0] g;
      rand_perm(a); rand_data(d);
      v = N'($urandom);
      for (int j = 0; j < N; j++) begin
        if (!v[j]) begin
          a[j*AW +: AW] = AW'($urandom);
          d[j*DW +: DW] = DW'($urandom);
        end
      end
      g = a;
      step(v, g, d, "R7");
    end

    repeat (LAT + 1) idle("R2");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule